// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between synchronous on-chip logic and an external asynchronous static RAM with a 16-bit bidirectional data bus split into two byte lanes. A client hands it one word or byte access at a time over a valid/ready handshake: an address, write data, a two-bit lane mask and a read/write flag. The controller then drives the RAM's active-low chip select, output enable, write enable and per-lane byte enables. Each strobe is held for a whole number of clock cycles. These counts are computed at elaboration from the clock period and the RAM's minimum timings, which are given in nanoseconds.

A read keeps chip select and output enable low until the address access time has passed. It samples the bus on the clock edge that ends that window and returns the word with a one-cycle valid pulse. A write drives the bus only while write enable is low. Write enable stays low long enough to cover the write pulse width, the address-to-end-of-write time and the data setup time. Chip select is then held until the full write cycle time has elapsed. One dead cycle separates every write from the next access, so the RAM's output drivers never meet the controller's. A sleep request parks the RAM deselected for data retention. Leaving that state waits out a recovery interval before any new access.

Top module: `asram_port`

## Requirements
- R1: After reset, chip select, output enable, write enable and both byte enables are high, the bus drive enable is low, reqReady is high and rdValid is low.
- R2: A read holds chip select and output enable low with write enable high for exactly RD_CYC = ceil(max(tRC, tAA, tOE) / clock period) cycles (20 at defaults). The bus is sampled on the edge that ends this window, and rdValid is high for exactly one cycle after that edge together with rdData.
- R3: Mask bit 0 selects the lower lane (bus bits 7:0, byte enable bit 0) and mask bit 1 selects the upper lane (bits 15:8, byte enable bit 1). A selected lane has its byte enable low for the whole access. A read returns zero in every unselected lane of rdData.
- R4: A write holds chip select and write enable low for exactly WE_CYC = ceil(max(tWP, tAW, tDW) / clock period) cycles (16 at defaults). Output enable stays high throughout, and output enable and write enable are never low together.
- R5: The bus drive enable is high exactly while write enable is low. It is released on the same edge that raises write enable, and the driven value is the request's write data.
- R6: Chip select stays low for max(ceil(tWC / clock period), WE_CYC) cycles in a write (20 at defaults). Write enable is high for the cycles after the write pulse.
- R7: After chip select rises at the end of a write, the controller spends exactly one cycle with reqReady low and all strobes high. A following read therefore asserts output enable only after two all-idle cycles.
- R8: Address, byte enables and write data do not change while chip select stays low.
- R9: reqReady is low while an access is in progress, and a request presented while reqReady is low has no effect on the RAM.
- R10: While sleepReq is high and the controller is idle, it enters retention: sleepAck is high, chip select is held high, reqReady is low and requests are ignored.
- R11: After sleepReq falls, reqReady stays low for REC_CYC = ceil(tREC / clock period) cycles before the next access may start, and the stored data is intact.
- R12: A request with mask 00 runs its full strobe sequence with both byte enables high, so the RAM contents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request present |
| reqReady | output | 1 | Request accepted on this edge when high with reqValid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqData | input | 16 | Write data |
| reqMask | input | 2 | Lane select; bit 0 lower byte, bit 1 upper byte |
| rdValid | output | 1 | One-cycle pulse marking rdData |
| rdData | output | 16 | Read word, unselected lanes zero |
| sleepReq | input | 1 | Request retention standby |
| sleepAck | output | 1 | Retention standby active |
| sramAddr | output | 18 | RAM address |
| sramCsN | output | 1 | RAM chip select, active low |
| sramOeN | output | 1 | RAM output enable, active low |
| sramWeN | output | 1 | RAM write enable, active low |
| sramBeN | output | 2 | RAM byte enables, active low; bit 0 lower lane |
| sramDqO | output | 16 | Data driven toward the RAM |
| sramDqEn | output | 1 | Drive enable for sramDqO onto the bus |
| sramDqI | input | 16 | Data sampled from the RAM bus |

## Verification
The assertions assume that reset is held for at least one clock edge and that the clock period parameter matches the real clock. They also assume that sleepReq and requests come only from the synchronous client, with no glitching. The stimulus drives every input on the falling edge so the controller samples settled values. It drops reqValid on the cycle after acceptance, which keeps it from issuing unintended back-to-back requests. A behavioural RAM model in the bench commits data only when write enable rises while chip select is low. It drives a filler pattern onto lanes that are not enabled, so any lane-gating fault shows up in rdData.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WRLOW,
    ST_WRTAIL,
    ST_TURN,
    ST_SLEEP,
    ST_WAKE
  } ctlState_t;

  // strobes from control to datapath; pin strobes are registered
  typedef struct packed {
    logic csN;
    logic oeN;
    logic weN;
    logic laneOn;
    logic drive;
    logic load;     // combinational: request accepted this edge
    logic capture;  // combinational: sample bus this edge
  } strobe_t;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctl.sv
module asram_ctl
  import asram_pkg::*;
#(
  parameter int CLK_NS   = 5,
  parameter int T_RC_NS  = 100,
  parameter int T_AA_NS  = 100,
  parameter int T_OE_NS  = 50,
  parameter int T_WC_NS  = 100,
  parameter int T_WP_NS  = 70,
  parameter int T_AW_NS  = 80,
  parameter int T_DW_NS  = 40,
  parameter int T_REC_NS = 5000000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    sleepReq,
  output logic    reqReady,
  output logic    sleepAck,
  output strobe_t stb
);

  localparam int RD_CYC   = imax(1, cdiv(imax(T_RC_NS, imax(T_AA_NS, T_OE_NS)), CLK_NS));
  localparam int WE_CYC   = imax(1, cdiv(imax(T_WP_NS, imax(T_AW_NS, T_DW_NS)), CLK_NS));
  localparam int WC_CYC   = imax(WE_CYC, cdiv(T_WC_NS, CLK_NS));
  localparam int TAIL_CYC = WC_CYC - WE_CYC;
  localparam int REC_CYC  = imax(1, cdiv(T_REC_NS, CLK_NS));
  localparam int CNT_MAX  = imax(REC_CYC, imax(RD_CYC, WC_CYC));
  localparam int CNT_W    = $clog2(CNT_MAX + 1);

  ctlState_t       state, stateNx;
  logic [CNT_W-1:0] cnt, cntNx;
  logic csN, oeN, weN, laneOn, drive;
  logic csNx, oeNx, weNx, laneOnNx, driveNx;
  logic load, capture;

  assign reqReady = (state == ST_IDLE) && !sleepReq;
  assign sleepAck = (state == ST_SLEEP);

  always_comb begin
    stateNx  = state;
    cntNx    = cnt;
    csNx     = csN;
    oeNx     = oeN;
    weNx     = weN;
    laneOnNx = laneOn;
    driveNx  = drive;
    load     = 1'b0;
    capture  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (sleepReq) begin
          stateNx = ST_SLEEP;
        end else if (reqValid) begin
          load     = 1'b1;
          csNx     = 1'b0;
          laneOnNx = 1'b1;
          if (reqWrite) begin
            stateNx = ST_WRLOW;
            weNx    = 1'b0;
            driveNx = 1'b1;
            cntNx   = CNT_W'(WE_CYC - 1);
          end else begin
            stateNx = ST_READ;
            oeNx    = 1'b0;
            cntNx   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_READ: begin
        if (cnt == '0) begin
          capture  = 1'b1;
          stateNx  = ST_IDLE;
          csNx     = 1'b1;
          oeNx     = 1'b1;
          laneOnNx = 1'b0;
        end else begin
          cntNx = cnt - 1'b1;
        end
      end
      ST_WRLOW: begin
        if (cnt == '0) begin
          weNx    = 1'b1;
          driveNx = 1'b0;
          if (TAIL_CYC > 0) begin
            stateNx = ST_WRTAIL;
            cntNx   = CNT_W'(imax(TAIL_CYC, 1) - 1);
          end else begin
            stateNx  = ST_TURN;
            csNx     = 1'b1;
            laneOnNx = 1'b0;
          end
        end else begin
          cntNx = cnt - 1'b1;
        end
      end
      ST_WRTAIL: begin
        if (cnt == '0) begin
          stateNx  = ST_TURN;
          csNx     = 1'b1;
          laneOnNx = 1'b0;
        end else begin
          cntNx = cnt - 1'b1;
        end
      end
      ST_TURN: stateNx = ST_IDLE;
      ST_SLEEP: begin
        if (!sleepReq) begin
          stateNx = ST_WAKE;
          cntNx   = CNT_W'(REC_CYC - 1);
        end
      end
      ST_WAKE: begin
        if (cnt == '0) stateNx = ST_IDLE;
        else cntNx = cnt - 1'b1;
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      csN    <= 1'b1;
      oeN    <= 1'b1;
      weN    <= 1'b1;
      laneOn <= 1'b0;
      drive  <= 1'b0;
    end else begin
      state  <= stateNx;
      cnt    <= cntNx;
      csN    <= csNx;
      oeN    <= oeNx;
      weN    <= weNx;
      laneOn <= laneOnNx;
      drive  <= driveNx;
    end
  end

  always_comb begin
    stb.csN     = csN;
    stb.oeN     = oeN;
    stb.weN     = weN;
    stb.laneOn  = laneOn;
    stb.drive   = drive;
    stb.load    = load;
    stb.capture = capture;
  end

  // ---- checks on the strobe sequence ----
  logic [CNT_W-1:0] weLowRun;
  logic [2:0]       sinceWe;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      weLowRun <= '0;
      sinceWe  <= 3'd7;
    end else begin
      weLowRun <= weN ? '0 : weLowRun + 1'b1;
      sinceWe  <= !weN ? 3'd0 : ((sinceWe == 3'd7) ? sinceWe : sinceWe + 3'd1);
    end
  end

  p_we_width_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(weN) |-> (weLowRun >= CNT_W'(WE_CYC)));

  p_oe_we_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(!oeN && !weN));

  p_drive_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(weN) |-> !drive);

  p_turn_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(oeN) |-> (sinceWe >= 3'd2));

  p_sleep_cs_r10: assert property (@(posedge clk) disable iff (!rstN)
    sleepAck |-> (csN && !reqReady));

  p_busy_ready_r9: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> !reqReady);

endmodule

// File: rtl/asram_dp.sv
module asram_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [DATA_W-1:0]    reqData,
  input  logic [DATA_W/8-1:0]  reqMask,
  output logic                 rdValid,
  output logic [DATA_W-1:0]    rdData,
  output logic [ADDR_W-1:0]    sramAddr,
  output logic                 sramCsN,
  output logic                 sramOeN,
  output logic                 sramWeN,
  output logic [DATA_W/8-1:0]  sramBeN,
  output logic [DATA_W-1:0]    sramDqO,
  output logic                 sramDqEn,
  input  logic [DATA_W-1:0]    sramDqI
);

  localparam int LANES = DATA_W / 8;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  maskQ;
  logic              validQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      dataQ  <= '0;
      maskQ  <= '0;
      validQ <= 1'b0;
    end else begin
      if (stb.load) begin
        addrQ <= reqAddr;
        dataQ <= reqData;
        maskQ <= reqMask;
      end
      validQ <= stb.capture;
    end
  end

  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    logic [7:0] laneRd;
    always_ff @(posedge clk) begin
      if (!rstN) laneRd <= '0;
      else if (stb.capture) laneRd <= maskQ[gl] ? sramDqI[gl*8 +: 8] : 8'h00;
    end
    assign rdData[gl*8 +: 8] = laneRd;
    assign sramBeN[gl]       = !(stb.laneOn && maskQ[gl]);
  end

  assign rdValid  = validQ;
  assign sramAddr = addrQ;
  assign sramDqO  = dataQ;
  assign sramDqEn = stb.drive;
  assign sramCsN  = stb.csN;
  assign sramOeN  = stb.oeN;
  assign sramWeN  = stb.weN;

  p_rd_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.csN && $past(!stb.csN)) |-> ($stable(addrQ) && $stable(dataQ) && $stable(maskQ)));

  p_drive_only_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.drive |-> (!stb.weN && !stb.csN));

endmodule

// File: rtl/asram_port.sv
module asram_port
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int CLK_NS   = 5,
  parameter int T_RC_NS  = 100,
  parameter int T_AA_NS  = 100,
  parameter int T_OE_NS  = 50,
  parameter int T_WC_NS  = 100,
  parameter int T_WP_NS  = 70,
  parameter int T_AW_NS  = 80,
  parameter int T_DW_NS  = 40,
  parameter int T_REC_NS = 5000000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [DATA_W-1:0]   reqData,
  input  logic [DATA_W/8-1:0] reqMask,
  output logic                rdValid,
  output logic [DATA_W-1:0]   rdData,
  input  logic                sleepReq,
  output logic                sleepAck,
  output logic [ADDR_W-1:0]   sramAddr,
  output logic                sramCsN,
  output logic                sramOeN,
  output logic                sramWeN,
  output logic [DATA_W/8-1:0] sramBeN,
  output logic [DATA_W-1:0]   sramDqO,
  output logic                sramDqEn,
  input  logic [DATA_W-1:0]   sramDqI
);

  strobe_t stb;

  asram_ctl #(
    .CLK_NS(CLK_NS), .T_RC_NS(T_RC_NS), .T_AA_NS(T_AA_NS), .T_OE_NS(T_OE_NS),
    .T_WC_NS(T_WC_NS), .T_WP_NS(T_WP_NS), .T_AW_NS(T_AW_NS), .T_DW_NS(T_DW_NS),
    .T_REC_NS(T_REC_NS)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .sleepReq(sleepReq), .reqReady(reqReady), .sleepAck(sleepAck), .stb(stb)
  );

  asram_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .reqAddr(reqAddr), .reqData(reqData), .reqMask(reqMask),
    .rdValid(rdValid), .rdData(rdData),
    .sramAddr(sramAddr), .sramCsN(sramCsN), .sramOeN(sramOeN), .sramWeN(sramWeN),
    .sramBeN(sramBeN), .sramDqO(sramDqO), .sramDqEn(sramDqEn), .sramDqI(sramDqI)
  );

endmodule

// File: tb/sim_asram_port.sv
`timescale 1ns/1ps
module sim_asram_port;

  localparam int RD  = 20;  // ceil(100/5)
  localparam int WE  = 16;  // ceil(max(70,80,40)/5)
  localparam int WC  = 20;  // ceil(100/5)
  localparam int REC = 40;  // ceil(200/5)

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, sleepReq = 1'b0;
  logic [17:0] reqAddr = '0;
  logic [15:0] reqData = '0;
  logic [1:0]  reqMask = '0;
  logic reqReady, rdValid, sleepAck, sramCsN, sramOeN, sramWeN, sramDqEn;
  logic [15:0] rdData, sramDqO, sramDqI;
  logic [17:0] sramAddr;
  logic [1:0]  sramBeN;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  asram_port #(.T_REC_NS(200)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqData(reqData), .reqMask(reqMask),
    .rdValid(rdValid), .rdData(rdData), .sleepReq(sleepReq), .sleepAck(sleepAck),
    .sramAddr(sramAddr), .sramCsN(sramCsN), .sramOeN(sramOeN), .sramWeN(sramWeN),
    .sramBeN(sramBeN), .sramDqO(sramDqO), .sramDqEn(sramDqEn), .sramDqI(sramDqI)
  );

  // behavioural RAM: commits at end of write overlap, fills disabled lanes with EE
  logic [15:0] mem [0:255];
  initial for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
  always @(posedge sramWeN) begin
    if (rstN && !sramCsN) begin
      if (!sramBeN[0]) mem[sramAddr[7:0]][7:0]  <= sramDqO[7:0];
      if (!sramBeN[1]) mem[sramAddr[7:0]][15:8] <= sramDqO[15:8];
    end
  end
  wire rdOn = !sramCsN && !sramOeN && sramWeN;
  assign sramDqI[7:0]  = (rdOn && !sramBeN[0]) ? mem[sramAddr[7:0]][7:0]  : 8'hEE;
  assign sramDqI[15:8] = (rdOn && !sramBeN[1]) ? mem[sramAddr[7:0]][15:8] : 8'hEE;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // continuous monitor sampled on the falling edge
  int idleRun = 0;
  int lastGap = 0;
  int monBad = 0;
  logic prevOeN = 1'b1, prevCsN = 1'b1;
  logic [17:0] prevAddr = '0;
  logic [1:0]  prevBe = 2'b11;
  always @(negedge clk) begin
    if (rstN) begin
      if (!sramOeN && !sramWeN) begin
        monBad++; $display("FAIL R4 oe/we overlap act=0 exp=1");
      end
      if (sramDqEn !== !sramWeN) begin
        monBad++; $display("FAIL R5 drive act=%0b exp=%0b", sramDqEn, !sramWeN);
      end
      if (!sramCsN && !prevCsN && (sramAddr !== prevAddr || sramBeN !== prevBe)) begin
        monBad++; $display("FAIL R8 addr act=%0h exp=%0h", sramAddr, prevAddr);
      end
      if (!sramWeN) idleRun = 0;
      else if (sramCsN && sramOeN) idleRun++;
      if (!sramOeN && prevOeN) lastGap = idleRun;
    end
    prevOeN = sramOeN; prevCsN = sramCsN; prevAddr = sramAddr; prevBe = sramBeN;
  end

  task automatic doWrite(input logic [17:0] a, input logic [15:0] d, input logic [1:0] m,
                         output int weCnt, output int csCnt, output bit oeSeen,
                         output logic [1:0] beSeen, output logic [15:0] dqSeen);
    weCnt = 0; csCnt = 0; oeSeen = 0;
    reqAddr = a; reqData = d; reqMask = m; reqWrite = 1'b1; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    beSeen = sramBeN; dqSeen = sramDqO;
    while (!sramCsN) begin
      if (!sramWeN) weCnt++;
      if (!sramOeN) oeSeen = 1;
      csCnt++;
      @(negedge clk);
    end
  endtask

  task automatic doRead(input logic [17:0] a, input logic [1:0] m,
                        output logic [15:0] d, output int oeCnt, output logic [1:0] beSeen,
                        output bit pulseOk);
    oeCnt = 0;
    reqAddr = a; reqMask = m; reqWrite = 1'b0; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    beSeen = sramBeN;
    while (!rdValid) begin
      if (!sramOeN && !sramCsN && sramWeN) oeCnt++;
      @(negedge clk);
    end
    d = rdData;
    @(negedge clk);
    pulseOk = !rdValid;
  endtask

  task automatic t_reset();
    check(sramCsN && sramOeN && sramWeN, "R1 strobes", {sramCsN, sramOeN, sramWeN}, 3'b111);
    check(sramBeN == 2'b11 && !sramDqEn, "R1 lanes/drive", {sramBeN, sramDqEn}, 3'b110);
    check(reqReady && !rdValid, "R1 ready/valid", {reqReady, rdValid}, 2'b10);
  endtask

  task automatic t_word();
    int we, cs, oc; bit oe, pk; logic [1:0] be; logic [15:0] dq, d;
    doWrite(18'h00010, 16'hA55A, 2'b11, we, cs, oe, be, dq);
    check(we == WE, "R4 we width", we, WE);
    check(!oe, "R4 oe high in write", oe, 0);
    check(cs == WC, "R6 cs width", cs, WC);
    check(dq == 16'hA55A, "R5 driven data", dq, 16'hA55A);
    check(!reqReady, "R7 turn cycle not ready", reqReady, 0);
    doRead(18'h00010, 2'b11, d, oc, be, pk);
    check(lastGap == 2, "R7 idle gap", lastGap, 2);
    check(oc == RD, "R2 oe width", oc, RD);
    check(d == 16'hA55A, "R2 read data", d, 16'hA55A);
    check(pk, "R2 single pulse", pk, 1);
  endtask

  task automatic t_lanes();
    int we, cs, oc; bit oe, pk; logic [1:0] be; logic [15:0] dq, d;
    doWrite(18'h00005, 16'h1234, 2'b11, we, cs, oe, be, dq);
    doWrite(18'h00005, 16'hAABB, 2'b01, we, cs, oe, be, dq);
    check(be == 2'b10, "R3 lower lane enable", be, 2'b10);
    doRead(18'h00005, 2'b11, d, oc, be, pk);
    check(d == 16'h12BB, "R3 lower write", d, 16'h12BB);
    doWrite(18'h00005, 16'hCCDD, 2'b10, we, cs, oe, be, dq);
    check(be == 2'b01, "R3 upper lane enable", be, 2'b01);
    doRead(18'h00005, 2'b10, d, oc, be, pk);
    check(d == 16'hCC00 && be == 2'b01, "R3 upper read", d, 16'hCC00);
    doRead(18'h00005, 2'b01, d, oc, be, pk);
    check(d == 16'h00BB, "R3 lower read", d, 16'h00BB);
  endtask

  task automatic t_mask0();
    int we, cs, oc; bit oe, pk; logic [1:0] be; logic [15:0] dq, d;
    doWrite(18'h00010, 16'hFFFF, 2'b00, we, cs, oe, be, dq);
    check(be == 2'b11 && we == WE, "R12 no lane enabled", {be, we[7:0]}, {2'b11, 8'(WE)});
    doRead(18'h00010, 2'b11, d, oc, be, pk);
    check(d == 16'hA55A, "R12 contents kept", d, 16'hA55A);
  endtask

  task automatic t_busy();
    int we, cs, oc; bit oe, pk; logic [1:0] be; logic [15:0] dq, d;
    bit readySeen = 0;
    reqAddr = 18'h00020; reqData = 16'h0F0F; reqMask = 2'b11; reqWrite = 1'b0; reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqAddr = 18'h00030; reqData = 16'h7777; reqWrite = 1'b1;
    for (int i = 0; i < 4; i++) begin
      if (reqReady) readySeen = 1;
      @(negedge clk);
    end
    reqValid = 1'b0;
    check(!readySeen, "R9 not ready while busy", readySeen, 0);
    while (!rdValid) @(negedge clk);
    @(negedge clk);
    doRead(18'h00030, 2'b11, d, oc, be, pk);
    check(d == 16'h0000, "R9 busy request ignored", d, 16'h0000);
  endtask

  task automatic t_sleep();
    int oc, waitCnt; bit pk, csLow; logic [1:0] be; logic [15:0] d;
    sleepReq = 1'b1;
    @(negedge clk); @(negedge clk);
    check(sleepAck && sramCsN && !reqReady, "R10 retention", {sleepAck, sramCsN, reqReady}, 3'b110);
    reqAddr = 18'h00005; reqData = 16'h9999; reqMask = 2'b11; reqWrite = 1'b1; reqValid = 1'b1;
    csLow = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!sramCsN) csLow = 1;
    end
    reqValid = 1'b0;
    check(!csLow, "R10 request ignored", csLow, 0);
    sleepReq = 1'b0;
    waitCnt = 0;
    @(negedge clk);
    while (!reqReady) begin waitCnt++; @(negedge clk); end
    check(waitCnt == REC, "R11 recovery wait", waitCnt, REC);
    doRead(18'h00005, 2'b11, d, oc, be, pk);
    check(d == 16'hCCBB, "R11 data retained", d, 16'hCCBB);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_word();
    t_lanes();
    t_mask0();
    t_busy();
    t_sleep();
    repeat (4) @(negedge clk);
    check(monBad == 0, "R4 R5 R8 monitor", monBad, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule